// File: doc/BRIEF.md
# Programmable Panel Raster Timing Generator

This block produces the raster timing for a flat panel driven over a parallel or low-voltage differential link. It is clocked by a fast channel clock. It divides that clock by a programmable integer to get a dot-rate strobe. It also keeps a pixel counter and a line counter, and decodes from them the horizontal and vertical sync, data-enable, a fetch-start pulse for the upstream pixel source and a line-match interrupt. A pin-release output tells the pad ring when the panel pins may be driven.

Software writes six word-wide registers through a simple write port. The geometry fields use minus-one encodings, and the vertical total is written as twice the line count. Geometry and divider values are staged and take effect only at a frame boundary. A run request starts the enable sequence, which walks through global enable, channel enable and pin release in that order, and tears it down in the reverse order.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held, pins_tri is 1, timing_live is 0, hsync, vsync, de, line_irq, fetch_start and dot_ce are 0, and pix_x and line_y are 0.
- R2: Register map, selected by cfg_addr. Address 0 is control: bit 0 is the run request, bit 1 inverts hsync, bit 2 inverts vsync. After a write that sets the run request, the global enable is set at the next edge, the channel enable one edge later (timing_live rises), and pins_tri falls one edge after that. After a write that clears the request, pins_tri rises first, then the channel enable clears (timing_live falls), then the global enable clears.
- R3: Address 5 bits 6:0 give the dot divide D, clamped to the range 7 to 15. While live, dot_ce is high for one channel clock out of every D.
- R4: Address 2 holds the horizontal total minus one in bits 31:16 and the back porch minus one in bits 15:0. Address 4 holds the hsync width minus one in bits 31:16. pix_x counts 0 to total-1, advancing on each dot_ce. hsync is active while pix_x is below the width.
- R5: Address 3 holds twice the frame line count in bits 31:16 and the vertical back porch minus one in bits 15:0. The line count is that field halved (a result of zero is taken as one). line_y advances when pix_x wraps and returns to 0 after the last line.
- R6: Address 1 holds the active width minus one in bits 31:16 and the active height minus one in bits 15:0. de is high only when pix_x is in [hbp, hbp+width) and line_y is in [vbp, vbp+height). Both back porches are counted from the start of sync.
- R7: A set invert bit flips the level of the matching sync output, including its idle level. The change shows one clock after the control write.
- R8: The start delay is 30 lines when the vertical blanking (lines minus height) is 32 or more, blanking minus 2 otherwise, and 0 when blanking is below 2. fetch_start pulses for one channel clock at the first clock of pixel 0 of that line.
- R9: line_irq pulses for one channel clock at the first clock of pixel 0 of line start delay plus 2.
- R10: Geometry and divider writes made while live take effect only at the end of the current frame. While idle they take effect at once.
- R11: While not live, the counters are held at zero, and de, dot_ce, line_irq and fetch_start stay low.
- R12: A vsync field of 0 in address 4 bits 15:0 gives vsync for exactly one line, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Active-area data enable |
| pix_x | output | 16 | Pixel counter |
| line_y | output | 16 | Line counter |
| fetch_start | output | 1 | Pulse at start of the delayed data line |
| line_irq | output | 1 | Line-match interrupt pulse |
| dot_ce | output | 1 | Dot-rate clock enable |
| timing_live | output | 1 | Global and channel enables both set |
| pins_tri | output | 1 | Panel pins released to high impedance |

## Verification
The bench goes after the points where the minus-one and doubled encodings meet the counters. A design that forgot to halve the vertical field would run frames twice as tall. A design that skipped the +1 decode would clip the active window by a pixel and a line. It checks that the enable order is exact: if the pin release came before the channel enable, live timing would be missing for the first cycle of driven pins. It writes a new divider and a new frame height in the middle of a frame. A design without shadowing would wrap the line counter late or stretch the current frame. The divider is driven below and above its legal range, and the start delay is taken on both sides of its 32-line knee.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int FW     = 16;
  localparam int DIVW   = 4;
  localparam int DCLK_W = 7;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SIZE = 3'd1,
    REG_HTIM = 3'd2,
    REG_VTIM = 3'd3,
    REG_SYNC = 3'd4,
    REG_DCLK = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [FW:0]     hact;
    logic [FW:0]     vact;
    logic [FW:0]     htot;
    logic [FW:0]     hbp;
    logic [FW:0]     vtot;
    logic [FW:0]     vbp;
    logic [FW:0]     hsw;
    logic [FW:0]     vsw;
    logic [FW:0]     dly;
    logic [DIVW-1:0] div;
  } geom_t;

  function automatic logic [FW:0] plus_one(input logic [FW-1:0] f);
    return {1'b0, f} + 1'b1;
  endfunction

  function automatic logic [FW:0] halve_lines(input logic [FW-1:0] f);
    logic [FW:0] v;
    v = {2'b00, f[FW-1:1]};
    return (v == '0) ? {{FW{1'b0}}, 1'b1} : v;
  endfunction

  function automatic logic [FW:0] start_delay(input logic [FW:0] vtot,
                                               input logic [FW:0] vact);
    if (vtot >= vact + 17'd32)      return 17'd30;
    else if (vtot >= vact + 17'd2)  return vtot - vact - 17'd2;
    else                            return '0;
  endfunction

  function automatic logic [DIVW-1:0] clamp_div(input logic [DCLK_W-1:0] f,
                                                input int lo, input int hi);
    if (int'(f) < lo)      return DIVW'(lo);
    else if (int'(f) > hi) return DIVW'(hi);
    else                   return f[DIVW-1:0];
  endfunction

  function automatic geom_t decode(input logic [31:0] size, input logic [31:0] htim,
                                   input logic [31:0] vtim, input logic [31:0] sync,
                                   input logic [DCLK_W-1:0] dclk,
                                   input int lo, input int hi);
    geom_t g;
    g.hact = plus_one(size[31:16]);
    g.vact = plus_one(size[15:0]);
    g.htot = plus_one(htim[31:16]);
    g.hbp  = plus_one(htim[15:0]);
    g.vtot = halve_lines(vtim[31:16]);
    g.vbp  = plus_one(vtim[15:0]);
    g.hsw  = plus_one(sync[31:16]);
    g.vsw  = plus_one(sync[15:0]);
    g.dly  = start_delay(g.vtot, g.vact);
    g.div  = clamp_div(dclk, lo, hi);
    return g;
  endfunction
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int DIV_MIN = 7,
  parameter int DIV_MAX = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        load_i,
  output logic        run_req_o,
  output logic        hinv_o,
  output logic        vinv_o,
  output geom_t       geom_o
);
  logic [31:0]       size_q, htim_q, vtim_q, sync_q;
  logic [DCLK_W-1:0] dclk_q;
  geom_t             shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req_o <= 1'b0;
      hinv_o    <= 1'b0;
      vinv_o    <= 1'b0;
      size_q    <= '0;
      htim_q    <= '0;
      vtim_q    <= '0;
      sync_q    <= '0;
      dclk_q    <= '0;
    end else if (we_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_CTRL: begin
          run_req_o <= wdata_i[0];
          hinv_o    <= wdata_i[1];
          vinv_o    <= wdata_i[2];
        end
        REG_SIZE: size_q <= wdata_i;
        REG_HTIM: htim_q <= wdata_i;
        REG_VTIM: vtim_q <= wdata_i;
        REG_SYNC: sync_q <= wdata_i;
        REG_DCLK: dclk_q <= wdata_i[DCLK_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= decode('0, '0, '0, '0, '0, DIV_MIN, DIV_MAX);
    else if (load_i) shadow_q <= decode(size_q, htim_q, vtim_q, sync_q, dclk_q,
                                        DIV_MIN, DIV_MAX);
  end

  assign geom_o = shadow_q;

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(shadow_q));
endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic run_o,
  output logic tri_o
);
  logic gen_q, cen_q, tri_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      cen_q <= 1'b0;
      tri_q <= 1'b1;
    end else if (req_i) begin
      if (!gen_q)      gen_q <= 1'b1;
      else if (!cen_q) cen_q <= 1'b1;
      else if (tri_q)  tri_q <= 1'b0;
    end else begin
      if (!tri_q)      tri_q <= 1'b1;
      else if (cen_q)  cen_q <= 1'b0;
      else if (gen_q)  gen_q <= 1'b0;
    end
  end

  assign run_o = gen_q & cen_q;
  assign tri_o = tri_q;

  // R2
  pins_need_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_q |-> (gen_q && cen_q));
  // R2
  global_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_q) |-> (tri_q && !cen_q));
endmodule

// File: rtl/lcdt_dotdiv.sv
module lcdt_dotdiv
  import lcdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o,
  output logic            phase0_o
);
  logic [DIVW-1:0] dc_q;

  assign tick_o   = run_i && (dc_q == div_i - 1'b1);
  assign phase0_o = run_i && (dc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dc_q <= '0;
    else if (!run_i) dc_q <= '0;
    else if (tick_o) dc_q <= '0;
    else             dc_q <= dc_q + 1'b1;
  end

  // R3
  dot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (dc_q == '0));
endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          phase0_i,
  input  geom_t         geom_i,
  input  logic          hinv_i,
  input  logic          vinv_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [FW-1:0] x_o,
  output logic [FW-1:0] y_o,
  output logic          fetch_o,
  output logic          irq_o,
  output logic          frame_end_o
);
  logic [FW-1:0] x_q, y_q;
  logic [FW:0]   xe, ye;
  logic          line_end, last_line, h_act, v_act, line_head;

  assign xe        = {1'b0, x_q};
  assign ye        = {1'b0, y_q};
  assign line_end  = (xe == geom_i.htot - 1'b1);
  assign last_line = (ye == geom_i.vtot - 1'b1);
  assign frame_end_o = tick_i && line_end && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !run_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (tick_i) begin
      if (line_end) begin
        x_q <= '0;
        y_q <= last_line ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign h_act     = (xe >= geom_i.hbp) && (xe < geom_i.hbp + geom_i.hact);
  assign v_act     = (ye >= geom_i.vbp) && (ye < geom_i.vbp + geom_i.vact);
  assign line_head = phase0_i && (x_q == '0);

  assign hsync_o = (run_i && (xe < geom_i.hsw)) ^ hinv_i;
  assign vsync_o = (run_i && (ye < geom_i.vsw)) ^ vinv_i;
  assign de_o    = run_i && h_act && v_act;
  assign fetch_o = line_head && (ye == geom_i.dly);
  assign irq_o   = line_head && (ye == geom_i.dly + 17'd2);
  assign x_o     = x_q;
  assign y_o     = y_q;

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (x_q == '0 && y_q == '0));
  // R4
  hcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (xe < geom_i.htot));
  // R5
  vcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (ye < geom_i.vtot));
  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int DIV_MIN = 7,
  parameter int DIV_MAX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] pix_x,
  output logic [FW-1:0] line_y,
  output logic          fetch_start,
  output logic          line_irq,
  output logic          dot_ce,
  output logic          timing_live,
  output logic          pins_tri
);
  logic  run_req, hinv, vinv, run, tick, phase0, frame_end, load;
  geom_t geom;

  assign load = !run || frame_end;

  lcdt_regs #(.DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .load_i(load), .run_req_o(run_req),
    .hinv_o(hinv), .vinv_o(vinv), .geom_o(geom));

  lcdt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(run_req), .run_o(run), .tri_o(pins_tri));

  lcdt_dotdiv u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(geom.div),
    .tick_o(tick), .phase0_o(phase0));

  lcdt_raster u_ras (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick), .phase0_i(phase0),
    .geom_i(geom), .hinv_i(hinv), .vinv_i(vinv), .hsync_o(hsync),
    .vsync_o(vsync), .de_o(de), .x_o(pix_x), .y_o(line_y),
    .fetch_o(fetch_start), .irq_o(line_irq), .frame_end_o(frame_end));

  assign dot_ce      = tick;
  assign timing_live = run;
endmodule

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hsync, vsync, de, fetch_start, line_irq, dot_ce, timing_live, pins_tri;
  logic [15:0] pix_x, line_y;

  int nchk = 0, nerr = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .line_y(line_y), .fetch_start(fetch_start),
    .line_irq(line_irq), .dot_ce(dot_ce), .timing_live(timing_live),
    .pins_tri(pins_tri));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int s_w, s_h, s_ht, s_hbp, s_vt2, s_vbp, s_hsw, s_vsw, s_div;
  int g_hact, g_vact, g_htot, g_hbp, g_vtot, g_vbp, g_hsw, g_vsw, g_dly, g_div;
  bit m_req, m_hinv, m_vinv, m_gen, m_cen, m_tri;
  int m_dc, m_x, m_y;

  task automatic m_load();
    int blank;
    g_hact = s_w + 1;   g_vact = s_h + 1;
    g_htot = s_ht + 1;  g_hbp  = s_hbp + 1;
    g_vtot = s_vt2 / 2; if (g_vtot == 0) g_vtot = 1;
    g_vbp  = s_vbp + 1; g_hsw = s_hsw + 1; g_vsw = s_vsw + 1;
    blank  = g_vtot - g_vact;
    g_dly  = (blank >= 32) ? 30 : (blank >= 2) ? blank - 2 : 0;
    g_div  = (s_div < 7) ? 7 : (s_div > 15) ? 15 : s_div;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_w = 0; s_h = 0; s_ht = 0; s_hbp = 0; s_vt2 = 0; s_vbp = 0;
      s_hsw = 0; s_vsw = 0; s_div = 0;
      m_load();
      m_req = 0; m_hinv = 0; m_vinv = 0;
      m_gen = 0; m_cen = 0; m_tri = 1;
      m_dc = 0; m_x = 0; m_y = 0;
    end else begin
      bit live, tk, fend;
      live = m_gen && m_cen;
      tk   = live && (m_dc == g_div - 1);
      fend = tk && (m_x == g_htot - 1) && (m_y == g_vtot - 1);
      if (!live) begin
        m_dc = 0; m_x = 0; m_y = 0;
      end else if (tk) begin
        m_dc = 0;
        if (m_x == g_htot - 1) begin
          m_x = 0;
          m_y = (m_y == g_vtot - 1) ? 0 : m_y + 1;
        end else m_x++;
      end else m_dc++;
      if (!live || fend) m_load();
      if (m_req) begin
        if (!m_gen) m_gen = 1; else if (!m_cen) m_cen = 1; else if (m_tri) m_tri = 0;
      end else begin
        if (!m_tri) m_tri = 1; else if (m_cen) m_cen = 0; else if (m_gen) m_gen = 0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin m_req = cfg_wdata[0]; m_hinv = cfg_wdata[1]; m_vinv = cfg_wdata[2]; end
          3'd1: begin s_w = cfg_wdata[31:16]; s_h = cfg_wdata[15:0]; end
          3'd2: begin s_ht = cfg_wdata[31:16]; s_hbp = cfg_wdata[15:0]; end
          3'd3: begin s_vt2 = cfg_wdata[31:16]; s_vbp = cfg_wdata[15:0]; end
          3'd4: begin s_hsw = cfg_wdata[31:16]; s_vsw = cfg_wdata[15:0]; end
          3'd5: s_div = cfg_wdata[6:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit live;
      bit e_hs, e_vs, e_de, e_irq, e_fetch, e_ce;
      live    = m_gen && m_cen;
      e_hs    = (live && m_x < g_hsw) ^ m_hinv;
      e_vs    = (live && m_y < g_vsw) ^ m_vinv;
      e_de    = live && m_x >= g_hbp && m_x < g_hbp + g_hact &&
                m_y >= g_vbp && m_y < g_vbp + g_vact;
      e_irq   = live && m_dc == 0 && m_x == 0 && m_y == g_dly + 2;
      e_fetch = live && m_dc == 0 && m_x == 0 && m_y == g_dly;
      e_ce    = live && m_dc == g_div - 1;
      chk(pins_tri == m_tri, "R2", "pins_tri", pins_tri, m_tri);
      chk(timing_live == live, "R2", "timing_live", timing_live, live);
      chk(dot_ce == e_ce, "R3", "dot_ce", dot_ce, e_ce);
      chk(pix_x == m_x, "R4 R11", "pix_x", pix_x, m_x);
      chk(line_y == m_y, "R5 R10", "line_y", line_y, m_y);
      chk(hsync == e_hs, "R4 R7", "hsync", hsync, e_hs);
      chk(vsync == e_vs, "R5 R7 R12", "vsync", vsync, e_vs);
      chk(de == e_de, "R6 R10", "de", de, e_de);
      chk(fetch_start == e_fetch, "R8", "fetch_start", fetch_start, e_fetch);
      chk(line_irq == e_irq, "R9", "line_irq", line_irq, e_irq);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic meas_div(input int exp);
    int n = 0;
    for (int i = 0; i < 40 && !dot_ce; i++) @(negedge clk);
    @(negedge clk); n = 1;
    while (!dot_ce && n < 40) begin @(negedge clk); n++; end
    chk(n == exp, "R3", "dot_ce spacing", n, exp);
  endtask

  task automatic wait_line_event(input bit use_irq, input int exp_line,
                                 input string req, input int limit);
    bit seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (use_irq ? line_irq : fetch_start) seen = 1;
    end
    chk(seen && line_y == exp_line, req, use_irq ? "irq line" : "fetch line",
        seen ? int'(line_y) : -1, exp_line);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pins_tri == 1'b1, "R1", "pins_tri in reset", pins_tri, 1);
    chk(timing_live == 1'b0 && dot_ce == 1'b0, "R1", "live/dot_ce in reset",
        timing_live, 0);
    chk(hsync == 0 && vsync == 0 && de == 0, "R1", "sync/de in reset", hsync | vsync | de, 0);
    chk(pix_x == 0 && line_y == 0, "R1", "counters in reset", pix_x + line_y, 0);
    chk(line_irq == 0 && fetch_start == 0, "R1", "pulses in reset", line_irq | fetch_start, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // Phase A: 8x4 active, 14 dots, 10 lines, divide field 3 clamps to 7
    wr(3'd1, {16'd7, 16'd3});
    wr(3'd2, {16'd13, 16'd2});
    wr(3'd3, {16'd20, 16'd2});
    wr(3'd4, {16'd1, 16'd0});
    wr(3'd5, 32'd3);
    wr(3'd0, 32'd1);
    @(negedge clk);
    chk(timing_live == 0 && pins_tri == 1, "R2", "after global enable", timing_live, 0);
    @(negedge clk);
    chk(timing_live == 1 && pins_tri == 1, "R2", "channel before pins", pins_tri, 1);
    @(negedge clk);
    chk(pins_tri == 0, "R2", "pins released", pins_tri, 0);
    meas_div(7);
    wait_line_event(1'b0, 4, "R8", 2000);
    wait_line_event(1'b1, 6, "R9", 2000);
    for (int i = 0; i < 2000 && !(line_y == 0 && vsync); i++) @(negedge clk);
    chk(vsync == 1 && line_y == 0, "R12", "vsync on line 0", line_y, 0);
    for (int i = 0; i < 2000 && line_y != 1; i++) @(negedge clk);
    chk(vsync == 0, "R12", "vsync off on line 1", vsync, 0);

    // Phase B: mid-frame change of height and divider (R10)
    for (int i = 0; i < 2000 && line_y != 1; i++) @(negedge clk);
    wr(3'd3, {16'd100, 16'd5});
    wr(3'd5, 32'd20);
    begin
      bit wrapped = 0;
      for (int i = 0; i < 1200 && !wrapped; i++) begin
        @(negedge clk);
        if (line_y == 0 && pix_x == 0) wrapped = 1;
      end
      chk(wrapped, "R10", "frame ends on old line count", wrapped, 1);
    end
    meas_div(15);
    wait_line_event(1'b0, 30, "R8", 12000);
    wait_line_event(1'b1, 32, "R9", 2000);
    begin
      bit reached = 0;
      for (int i = 0; i < 12000 && !reached; i++) begin
        @(negedge clk);
        if (line_y == 40) reached = 1;
      end
      chk(reached, "R5", "halved line count reaches 40", reached, 1);
    end

    // Phase C: polarity inversion
    wr(3'd0, 32'd7);
    for (int i = 0; i < 3000 && !(pix_x == 0 && line_y == 0); i++) @(negedge clk);
    chk(hsync == 0 && vsync == 0, "R7", "inverted syncs active low", hsync | vsync, 0);
    repeat (1500) @(negedge clk);

    // Phase D: disable keeping inversion, then check idle levels
    wr(3'd0, 32'd6);
    @(negedge clk);
    chk(pins_tri == 1 && timing_live == 1, "R2", "pins tri before channel off", timing_live, 1);
    @(negedge clk);
    chk(timing_live == 0, "R2", "channel off", timing_live, 0);
    repeat (5) @(negedge clk);
    chk(pix_x == 0 && line_y == 0, "R11", "counters idle", pix_x + line_y, 0);
    chk(de == 0 && dot_ce == 0 && line_irq == 0, "R11", "idle strobes", de | dot_ce, 0);
    chk(hsync == 1 && vsync == 1, "R7", "inverted idle level", hsync & vsync, 1);

    // Phase E: idle writes take effect at once, divide 11
    wr(3'd0, 32'd0);
    wr(3'd3, {16'd20, 16'd2});
    wr(3'd5, 32'd11);
    wr(3'd0, 32'd1);
    repeat (4) @(negedge clk);
    meas_div(11);
    wait_line_event(1'b1, 6, "R9", 3000);
    repeat (1500) @(negedge clk);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule